// File: doc/BRIEF.md
# Banked Memory Cycle Sequencer with Odd Parity

This block runs one complete memory cycle for every frame of twelve timing pulses. On entry to the first pulse it captures a 12-bit address and a bank number. The top two address bits choose the bank: erasable bank 0, fixed bank 1, fixed bank 2, or the bank number supplied on the bank input. The low ten bits pick a word inside that 1K-word bank. The selected word is moved into a buffer register. An erasable word is read destructively and is present from pulse 6. A fixed word is present from pulse 7.

During pulses 7 to 10 the surrounding processor may read the buffer or overwrite it. When pulse 10 ends, the buffer is always written back to the erasable location, with fresh parity, whether it was changed or not. Fixed memory is never written. Each stored word has 15 data bits and one parity bit that makes the count of ones odd. Parity is checked on every load into the buffer, and a mismatch sets an alarm that stays set until it is cleared.

Top module: `core_cycle_ctrl`

## Requirements
- R1: `cur_tp` is 0 after reset. Each cycle with `tp_tick` high moves it forward by one: from 0 or 12 to 1, otherwise n to n+1. It holds its value while `tp_tick` is low.
- R2: `addr_in` and `bank_in` are sampled only on the tick that enters pulse 1. Changes to them later in the frame do not affect that cycle.
- R3: The effective bank is `addr_in[11:10]`, except that the value 3 takes `bank_in` instead. Effective bank 0 is the erasable bank; any other value n is fixed bank n. The word offset is `addr_in[9:0]`.
- R4: An erasable word appears on `buf_data` when pulse 6 is entered. A fixed word appears when pulse 7 is entered, and during pulse 6 of a fixed cycle the buffer still holds its previous contents.
- R5: `buf_valid` is high exactly while `cur_tp` is 7 to 10. A `wr_en` write replaces the buffer only in those pulses and is ignored in all other pulses.
- R6: On leaving pulse 10, the buffer, including a write made in that same clock, is stored back into the erasable word. Later reads return it, whether it was modified or not.
- R7: A cycle on a fixed address never alters fixed contents, even when the buffer was overwritten.
- R8: Fixed bank b, word w holds the data `{b zero-extended to 5 bits, w} ^ 15'h1B6D`. Its parity is odd, except that every fixed word with offset 10'h3FF carries a wrong (even) parity bit as a test pattern.
- R9: Each load into the buffer checks that the 16 stored bits hold an odd count of ones. An even count sets `par_alarm` in the same clock as the load.
- R10: `par_alarm` stays set until `alarm_clr` is high for a clock. If a clear and a parity error arrive in the same clock, the error wins.
- R11: After reset, `buf_data` is 0, `par_alarm` is 0, and every erasable word reads as data 0 with correct parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tp_tick | input | 1 | Advance to the next timing pulse |
| addr_in | input | 12 | Bank select [11:10] and word offset [9:0] |
| bank_in | input | 3 | Bank number used when the select bits are 3 |
| wr_en | input | 1 | Processor overwrite of the buffer |
| wr_data | input | 15 | Data for the buffer overwrite |
| alarm_clr | input | 1 | Clears the parity alarm |
| cur_tp | output | 4 | Current pulse number, 0 when idle |
| buf_valid | output | 1 | Buffer may be read or overwritten |
| buf_data | output | 15 | Buffer register contents |
| par_alarm | output | 1 | Sticky parity alarm |

## Verification
The assertions assume that `tp_tick` moves the frame through whole twelve-pulse cycles. They also assume that destructive clearing and write-back never fall in the same clock, which holds because they sit in pulses 5 and 10. The stimulus always completes each frame before starting the next, changes the address only at the start of a frame except in the one deliberate mid-frame case, and holds `tp_tick` low only for short gaps in the middle of a frame. Alarm clears are issued only between frames, so the sticky behaviour is seen at frame boundaries.

// File: rtl/ccc_pkg.sv
package ccc_pkg;

   localparam int TP_W = 4;
   typedef logic [TP_W-1:0] tp_t;

   // pulse slots: the ordering is behaviour, not layout
   localparam tp_t TP_IDLE    = 4'd0;
   localparam tp_t TP_FIRST   = 4'd1;
   localparam tp_t TP_ERA_RDY = 4'd6;
   localparam tp_t TP_FIX_RDY = 4'd7;
   localparam tp_t TP_WIN_LO  = 4'd7;
   localparam tp_t TP_WIN_HI  = 4'd10;
   localparam tp_t TP_LAST    = 4'd12;

   typedef enum logic {
      REG_ERASABLE = 1'b0,
      REG_FIXED    = 1'b1
   } region_e;

endpackage

// File: rtl/ccc_parity.sv
module ccc_parity #(
   parameter int W   = 15,
   parameter bit ODD = 1'b1
) (
   input  logic [W-1:0] data,
   output logic         fill
);
   generate
      if (ODD) begin : g_odd
         assign fill = ~(^data);
      end else begin : g_even
         assign fill = ^data;
      end
   endgenerate
endmodule

// File: rtl/ccc_pulse_seq.sv
module ccc_pulse_seq
   import ccc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output tp_t  tp_q,
   output logic start
);
   assign start = tick && ((tp_q == TP_IDLE) || (tp_q == TP_LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tp_q <= TP_IDLE;
      end else if (start) begin
         tp_q <= TP_FIRST;
      end else if (tick) begin
         tp_q <= tp_q + tp_t'(1);
      end
   end

   // R1
   tp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && tp_q == TP_LAST) |=> (tp_q == TP_FIRST));

   // R1
   tp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(tp_q));

   // R1
   tp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tp_q <= TP_LAST);
endmodule

// File: rtl/ccc_bank_map.sv
module ccc_bank_map
   import ccc_pkg::*;
#(
   parameter int SEL_W   = 2,
   parameter int WORD_AW = 10,
   parameter int BANK_W  = 3
) (
   input  logic [SEL_W+WORD_AW-1:0] addr,
   input  logic [BANK_W-1:0]        bank,
   output logic [BANK_W-1:0]        eff_bank,
   output region_e                  region,
   output logic [WORD_AW-1:0]       word
);
   localparam logic [SEL_W-1:0] SEL_ESC = '1;

   logic [SEL_W-1:0] sel;

   assign sel  = addr[SEL_W+WORD_AW-1:WORD_AW];
   assign word = addr[WORD_AW-1:0];

   always_comb begin
      if (sel == SEL_ESC) begin
         eff_bank = bank;
      end else begin
         eff_bank = BANK_W'(sel);
      end
      region = (eff_bank == '0) ? REG_ERASABLE : REG_FIXED;
   end
endmodule

// File: rtl/ccc_erasable_ram.sv
module ccc_erasable_ram #(
   parameter int                AW       = 10,
   parameter int                W        = 16,
   parameter logic [W-1:0]      PARK     = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] word,
   input  logic          clr_en,
   input  logic          wr_en,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata
);
   localparam int DEPTH = 1 << AW;

   logic [W-1:0] mem [DEPTH];

   assign rdata = mem[word];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= PARK;
         end
      end else if (wr_en) begin
         mem[word] <= wdata;
      end else if (clr_en) begin
         mem[word] <= '0;
      end
   end

   // R6
   rd_wb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_en && wr_en));
endmodule

// File: rtl/ccc_fixed_rom.sv
module ccc_fixed_rom #(
   parameter int              AW         = 10,
   parameter int              DATA_W     = 15,
   parameter int              BANK_W     = 3,
   parameter logic [DATA_W-1:0] SEED     = 15'h1B6D,
   parameter bit              ODD        = 1'b1,
   parameter bit              TEST_WORDS = 1'b1
) (
   input  logic [BANK_W-1:0] bank,
   input  logic [AW-1:0]     word,
   output logic [DATA_W:0]   q
);
   localparam int HI_W = DATA_W - AW;
   localparam logic [AW-1:0] TEST_OFS = '1;

   logic [DATA_W-1:0] data;
   logic              good_par;
   logic              spoil;

   assign data = {HI_W'(bank), word} ^ SEED;

   ccc_parity #(.W(DATA_W), .ODD(ODD)) i_par (
      .data (data),
      .fill (good_par)
   );

   generate
      if (TEST_WORDS) begin : g_test
         assign spoil = (word == TEST_OFS);
      end else begin : g_plain
         assign spoil = 1'b0;
      end
   endgenerate

   assign q = {good_par ^ spoil, data};
endmodule

// File: rtl/core_cycle_ctrl.sv
module core_cycle_ctrl
   import ccc_pkg::*;
#(
   parameter int                DATA_W     = 15,
   parameter int                WORD_AW    = 10,
   parameter int                SEL_W      = 2,
   parameter int                BANK_W     = 3,
   parameter logic [DATA_W-1:0] ROM_SEED   = 15'h1B6D,
   parameter bit                ODD_PARITY = 1'b1,
   parameter bit                TEST_WORDS = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tp_tick,
   input  logic [SEL_W+WORD_AW-1:0] addr_in,
   input  logic [BANK_W-1:0]        bank_in,
   input  logic                     wr_en,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     alarm_clr,
   output logic [TP_W-1:0]          cur_tp,
   output logic                     buf_valid,
   output logic [DATA_W-1:0]        buf_data,
   output logic                     par_alarm
);
   localparam int              ADDR_W = SEL_W + WORD_AW;
   localparam int              WORD_W = DATA_W + 1;
   localparam logic [WORD_W-1:0] PARK = ODD_PARITY ? {1'b1, {DATA_W{1'b0}}} : '0;

   if (DATA_W <= WORD_AW) begin : g_bad_data_w
      $error("DATA_W must exceed WORD_AW");
   end
   if (BANK_W < SEL_W) begin : g_bad_bank_w
      $error("BANK_W must be at least SEL_W");
   end
   if (BANK_W > DATA_W - WORD_AW) begin : g_bad_rom_w
      $error("bank number must fit in the fixed data pattern");
   end

   tp_t                 tp_q;
   logic                start;
   logic [ADDR_W-1:0]   addr_q;
   logic [BANK_W-1:0]   bank_q;
   logic [BANK_W-1:0]   eff_bank;
   region_e             region;
   logic [WORD_AW-1:0]  word;
   logic [WORD_W-1:0]   ram_q;
   logic [WORD_W-1:0]   rom_q;
   logic [DATA_W-1:0]   buf_q;
   logic [DATA_W-1:0]   buf_nx;
   logic                wb_par;
   logic                load_e;
   logic                load_f;
   logic                wr_ok;
   logic                wb_fire;
   logic                par_err;
   logic                alarm_q;

   ccc_pulse_seq i_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tp_tick),
      .tp_q  (tp_q),
      .start (start)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         bank_q <= '0;
      end else if (start) begin
         addr_q <= addr_in;
         bank_q <= bank_in;
      end
   end

   ccc_bank_map #(.SEL_W(SEL_W), .WORD_AW(WORD_AW), .BANK_W(BANK_W)) i_map (
      .addr     (addr_q),
      .bank     (bank_q),
      .eff_bank (eff_bank),
      .region   (region),
      .word     (word)
   );

   assign load_e  = tp_tick && (tp_q == TP_ERA_RDY - tp_t'(1)) && (region == REG_ERASABLE);
   assign load_f  = tp_tick && (tp_q == TP_FIX_RDY - tp_t'(1)) && (region == REG_FIXED);
   assign wr_ok   = wr_en && (tp_q >= TP_WIN_LO) && (tp_q <= TP_WIN_HI);
   assign wb_fire = tp_tick && (tp_q == TP_WIN_HI) && (region == REG_ERASABLE);

   always_comb begin
      if (load_e) begin
         buf_nx = ram_q[DATA_W-1:0];
      end else if (load_f) begin
         buf_nx = rom_q[DATA_W-1:0];
      end else if (wr_ok) begin
         buf_nx = wr_data;
      end else begin
         buf_nx = buf_q;
      end
   end

   ccc_parity #(.W(DATA_W), .ODD(ODD_PARITY)) i_wb_par (
      .data (buf_nx),
      .fill (wb_par)
   );

   ccc_erasable_ram #(.AW(WORD_AW), .W(WORD_W), .PARK(PARK)) i_ram (
      .clk    (clk),
      .rst_n  (rst_n),
      .word   (word),
      .clr_en (load_e),
      .wr_en  (wb_fire),
      .wdata  ({wb_par, buf_nx}),
      .rdata  (ram_q)
   );

   ccc_fixed_rom #(
      .AW         (WORD_AW),
      .DATA_W     (DATA_W),
      .BANK_W     (BANK_W),
      .SEED       (ROM_SEED),
      .ODD        (ODD_PARITY),
      .TEST_WORDS (TEST_WORDS)
   ) i_rom (
      .bank (eff_bank),
      .word (word),
      .q    (rom_q)
   );

   assign par_err = (load_e && ((^ram_q) != ODD_PARITY)) ||
                    (load_f && ((^rom_q) != ODD_PARITY));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q   <= '0;
         alarm_q <= 1'b0;
      end else begin
         buf_q <= buf_nx;
         if (par_err) begin
            alarm_q <= 1'b1;
         end else if (alarm_clr) begin
            alarm_q <= 1'b0;
         end
      end
   end

   assign cur_tp    = tp_q;
   assign buf_valid = (tp_q >= TP_WIN_LO) && (tp_q <= TP_WIN_HI);
   assign buf_data  = buf_q;
   assign par_alarm = alarm_q;

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(addr_q) && $stable(bank_q));

   // R5
   buf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_valid && !load_e && !load_f) |=> $stable(buf_q));

   // R10
   alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (par_alarm && !alarm_clr) |=> par_alarm);

   // R9
   alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(par_alarm) |-> $past(load_e || load_f));
endmodule

// File: tb/test_core_cycle_ctrl.sv
`timescale 1ns/1ps
module test_core_cycle_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tp_tick = 1'b0;
   logic [11:0] addr_in = '0;
   logic [2:0]  bank_in = '0;
   logic        wr_en = 1'b0;
   logic [14:0] wr_data = '0;
   logic        alarm_clr = 1'b0;
   logic [3:0]  cur_tp;
   logic        buf_valid;
   logic [14:0] buf_data;
   logic        par_alarm;

   int checks = 0;
   int errors = 0;
   int prev_tp = 0;
   bit exp_alarm = 1'b0;
   bit done = 1'b0;

   typedef struct {
      logic [14:0] data;
      bit          alarm;
      string       tag;
   } exp_t;

   exp_t sb[$];

   always #2.5 clk = ~clk;

   core_cycle_ctrl i_core_cycle_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .tp_tick   (tp_tick),
      .addr_in   (addr_in),
      .bank_in   (bank_in),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .alarm_clr (alarm_clr),
      .cur_tp    (cur_tp),
      .buf_valid (buf_valid),
      .buf_data  (buf_data),
      .par_alarm (par_alarm)
   );

   function automatic logic [14:0] rom_val(input logic [2:0] b, input logic [9:0] w);
      return {2'b00, b, w} ^ 15'h1B6D;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pop one expectation each time pulse 7 is entered
   logic [3:0] mon_last = '0;
   always @(negedge clk) begin
      if (rst_n && cur_tp == 4'd7 && mon_last != 4'd7) begin
         if (sb.size() == 0) begin
            check(1'b0, "R4 unexpected load", buf_data, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(buf_data == e.data, {e.tag, " data"}, buf_data, e.data);
            check(par_alarm == e.alarm, {"R9 alarm ", e.tag}, par_alarm, e.alarm);
         end
      end
      mon_last = cur_tp;
   end

   task automatic do_cycle(input logic [11:0] a, input logic [2:0] b,
                           input bit late, input logic [11:0] a_late,
                           input bit wr, input logic [14:0] wd, input int wtp,
                           input int gap_at, input bit chk6, input logic [14:0] exp6,
                           input logic [14:0] exp_d, input string tag);
      exp_t e;
      e.data = exp_d;
      e.alarm = exp_alarm;
      e.tag = tag;
      sb.push_back(e);
      for (int p = 1; p <= 12; p++) begin
         @(negedge clk);
         check(int'(cur_tp) == ((p == 1) ? prev_tp : p - 1), "R1 pulse count", cur_tp,
               (p == 1) ? prev_tp : p - 1);
         check(buf_valid == (cur_tp >= 4'd7 && cur_tp <= 4'd10), "R5 window flag",
               buf_valid, (cur_tp >= 4'd7 && cur_tp <= 4'd10));
         if (p == 7 && chk6) begin
            check(buf_data == exp6, "R4 pulse6 buffer", buf_data, exp6);
         end
         if (p == gap_at) begin
            tp_tick = 1'b0;
            wr_en = 1'b0;
            for (int g = 0; g < 3; g++) begin
               @(negedge clk);
               check(int'(cur_tp) == p - 1, "R1 hold without tick", cur_tp, p - 1);
            end
         end
         tp_tick = 1'b1;
         if (p == 1) begin
            addr_in = a;
            bank_in = b;
         end
         if (late && p == 3) begin
            addr_in = a_late;
            bank_in = 3'd6;
         end
         wr_en = wr && (p - 1 == wtp);
         wr_data = wd;
      end
      @(negedge clk);
      tp_tick = 1'b0;
      wr_en = 1'b0;
      prev_tp = 12;
   endtask

   task automatic clear_alarm();
      @(negedge clk);
      alarm_clr = 1'b1;
      @(negedge clk);
      alarm_clr = 1'b0;
      exp_alarm = 1'b0;
      check(par_alarm == 1'b0, "R10 clear", par_alarm, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check(cur_tp == 4'd0, "R11 reset pulse", cur_tp, 0);
      check(par_alarm == 1'b0, "R11 reset alarm", par_alarm, 0);
      check(buf_data == 15'h0, "R11 reset buffer", buf_data, 0);
      check(buf_valid == 1'b0, "R11 reset window", buf_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11/R4: erasable word after reset reads 0
      do_cycle(12'h005, 3'd0, 0, 0, 0, 0, 0, 0, 1, 15'h0, 15'h0, "R11 erasable reset");
      // R6: write at pulse 8
      do_cycle(12'h005, 3'd0, 0, 0, 1, 15'h1234, 8, 0, 0, 0, 15'h0, "R6 write");
      do_cycle(12'h005, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 15'h1234, "R6 readback");
      do_cycle(12'h005, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 15'h1234, "R6 restore");
      // R3/R8 fixed bank 1; R4 old buffer at pulse 6
      do_cycle(12'h4AB, 3'd0, 0, 0, 0, 0, 0, 0, 1, 15'h1234, rom_val(3'd1, 10'h0AB), "R8 fixed bank1");
      // R3 fixed bank 2 with a tick gap (R1)
      do_cycle(12'h900, 3'd0, 0, 0, 0, 0, 0, 5, 0, 0, rom_val(3'd2, 10'h100), "R3 fixed bank2");
      // R3 escape code picks bank input
      do_cycle(12'hC42, 3'd5, 0, 0, 0, 0, 0, 0, 0, 0, rom_val(3'd5, 10'h042), "R3 escape bank5");
      // R3 escape with bank 0 means erasable; R4 erasable ready at pulse 6
      do_cycle(12'hC05, 3'd0, 0, 0, 0, 0, 0, 0, 1, 15'h1234, 15'h1234, "R3 escape bank0");
      // R7 overwrite of a fixed word is not stored
      do_cycle(12'hC10, 3'd3, 0, 0, 1, 15'h7FFF, 9, 0, 0, 0, rom_val(3'd3, 10'h010), "R7 fixed write");
      do_cycle(12'hC10, 3'd3, 0, 0, 0, 0, 0, 0, 0, 0, rom_val(3'd3, 10'h010), "R7 fixed intact");
      // R5 writes outside the window are ignored
      do_cycle(12'h006, 3'd0, 0, 0, 1, 15'h0555, 6, 0, 0, 0, 15'h0, "R5 write at pulse6");
      do_cycle(12'h006, 3'd0, 0, 0, 1, 15'h0777, 11, 0, 0, 0, 15'h0, "R5 write at pulse11");
      do_cycle(12'h006, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 15'h0, "R5 nothing stored");
      // R2 mid-frame address change is ignored
      do_cycle(12'h005, 3'd0, 1, 12'h4AB, 0, 0, 0, 0, 0, 0, 15'h1234, "R2 late address");
      // R6 write in the last window pulse, top erasable word, no alarm (R9)
      do_cycle(12'h3FF, 3'd0, 0, 0, 1, 15'h7FFF, 10, 0, 0, 0, 15'h0, "R6 edge write");
      do_cycle(12'h3FF, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 15'h7FFF, "R6 edge readback");
      // R9 bad parity test word raises the alarm
      exp_alarm = 1'b1;
      do_cycle(12'h7FF, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, rom_val(3'd1, 10'h3FF), "R9 bad parity");
      // R10 stays set over a clean cycle
      do_cycle(12'h005, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 15'h1234, "R10 sticky");
      clear_alarm();
      do_cycle(12'h900, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, rom_val(3'd2, 10'h100), "R10 after clear");

      repeat (4) @(negedge clk);
      check(sb.size() == 0, "R4 all loads seen", sb.size(), 0);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=finish", cyc);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule